// File: doc/BRIEF.md
# Tristate Phase-Frequency Comparator with Lock Monitor

This block is the digital comparison core of an integer-N phase-locked loop. It receives two pulse trains in one fast sampling clock domain: the divided reference and the divided local-oscillator signal. It turns the order of their rising edges into UP and DOWN enables for an external charge pump. When neither enable is active the pump output floats. The phase error of every comparison is measured in sampling-clock cycles. A lock flag is raised once a run of seven consecutive comparisons has each stayed inside a small window.

A 2-bit strap input selects one of four operating states. Two of them run the pump at a low or high current. The other two switch the pump off and disable the lock monitor. One strap state also turns off the loop-filter amplifier. The analog pump, loop filter and lock-pin driver sit outside this block and are driven by the enable outputs.

Top module: `pfd_lock_core`

## Requirements
- R1: While rst_ni is low, up_o, dn_o and lock_o are 0. After reset release they stay 0 until a divider rising edge or a completed run.
- R2: A rising edge on ref_pulse_i sampled at a clock edge sets up_o at that edge. A rising edge on lo_pulse_i sets dn_o the same way. Each enable stays set until both are set. The inputs are synchronous to clk_i.
- R3: Once both enables are set, both clear at the next clock edge. Both therefore overlap for exactly one cycle, and that includes simultaneous edges.
- R4: mode_i encoding: 2'b00 is low current, 2'b01 is mid, 2'b10 is open and 2'b11 is high current. In the mid and open states up_o and dn_o are held 0.
- R5: amp_en_o is 0 only when mode_i is 2'b10 (open). It is 1 in the other three states.
- R6: The phase error of a comparison is the number of clock edges from the edge that sets the first enable to the edge that sets the second. lock_o goes 1 at the edge after the seventh consecutive comparison whose error is at most WIN_CYC cycles. After six such comparisons it is still 0.
- R7: A comparison with an error above WIN_CYC clears the run and drops lock_o. Seven further good comparisons are then needed.
- R8: In the mid and open states (mode_i 2'b01 or 2'b10), lock_o is 0 and the run is cleared. Seven good comparisons are needed after the strap returns to an enabled state.
- R9: cp_hi_o is 1 only for mode_i 2'b11 (high current). It is 0 in the other three states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_pulse_i | input | 1 | Divided reference pulse |
| lo_pulse_i | input | 1 | Divided oscillator pulse |
| mode_i | input | 2 | Strap state: 00 low, 01 mid, 10 open, 11 high |
| up_o | output | 1 | Charge-pump source enable |
| dn_o | output | 1 | Charge-pump sink enable |
| cp_hi_o | output | 1 | High pump current select |
| amp_en_o | output | 1 | Loop-filter amplifier enable |
| lock_o | output | 1 | Lock indication |

## Verification
The bench drives comparisons whose error sits exactly at WIN_CYC and one cycle beyond it. A comparator that is off by one would then lock on a bad run or reject a good one. It also checks that six good comparisons leave lock_o low and the seventh raises it, to catch a wrong run length. It checks that a single bad comparison in a locked run drops lock_o at once, and that a strap excursion to mid or open wipes the run rather than pausing it. Simultaneous edges and one-cycle leads test the one-cycle overlap and clear of the enables. A detector that held both enables, or dropped a new edge during the clear, would show this at the ports.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef enum logic [1:0] {
    STRAP_LOW  = 2'b00,
    STRAP_MID  = 2'b01,
    STRAP_OPEN = 2'b10,
    STRAP_HIGH = 2'b11
  } strap_e;

  typedef struct packed {
    logic pump_en;
    logic cp_hi;
    logic amp_en;
    logic lock_en;
  } ctrl_t;

  function automatic ctrl_t decode_strap(logic [1:0] s);
    ctrl_t c;
    c = '0;
    unique case (strap_e'(s))
      STRAP_LOW:  begin c.pump_en = 1'b1; c.amp_en = 1'b1; c.lock_en = 1'b1; end
      STRAP_HIGH: begin c.pump_en = 1'b1; c.cp_hi = 1'b1; c.amp_en = 1'b1; c.lock_en = 1'b1; end
      STRAP_MID:  begin c.amp_en = 1'b1; end
      STRAP_OPEN: begin c = '0; end
      default:    c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pfd_mode_dec.sv
module pfd_mode_dec
  import pfd_pkg::*;
(
  input  logic [1:0] mode_i,
  output ctrl_t      ctrl_o
);
  always_comb ctrl_o = decode_strap(mode_i);
endmodule

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= sig_i[g];
    end
    assign rise_o[g] = sig_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/pfd_tristate.sv
module pfd_tristate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_rise_i,
  input  logic lo_rise_i,
  output logic up_q_o,
  output logic dn_q_o,
  output logic both_o
);
  logic up_q, dn_q, up_d, dn_d, both;

  assign both = up_q & dn_q;

  // new edge may set a flag even during the clear cycle
  always_comb begin
    up_d = ref_rise_i | (up_q & ~both);
    dn_d = lo_rise_i  | (dn_q & ~both);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

  assign up_q_o = up_q;
  assign dn_q_o = dn_q;
  assign both_o = both;
endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det #(
  parameter int unsigned WIN_CYC  = 25,
  parameter int unsigned LOCK_RUN = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic up_q_i,
  input  logic dn_q_i,
  input  logic both_i,
  output logic locked_o
);
  localparam int unsigned ERR_MAX = WIN_CYC + 1;
  localparam int unsigned ERR_W   = $clog2(ERR_MAX + 1);
  localparam int unsigned RUN_W   = $clog2(LOCK_RUN + 1);

  logic [ERR_W-1:0] err_q;
  logic [RUN_W-1:0] run_q;
  logic             good;

  // error counter saturates one past the window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     err_q <= '0;
    else if (both_i)                 err_q <= '0;
    else if ((up_q_i ^ dn_q_i) && (err_q != ERR_W'(ERR_MAX)))
                                     err_q <= err_q + 1'b1;
  end

  assign good = (err_q <= ERR_W'(WIN_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_q <= '0;
    else if (!enable_i)   run_q <= '0;
    else if (both_i) begin
      if (!good)                           run_q <= '0;
      else if (run_q != RUN_W'(LOCK_RUN))  run_q <= run_q + 1'b1;
    end
  end

  assign locked_o = enable_i & (run_q == RUN_W'(LOCK_RUN));
endmodule

// File: rtl/pfd_lock_core.sv
module pfd_lock_core
  import pfd_pkg::*;
#(
  parameter int unsigned WIN_CYC  = 25,
  parameter int unsigned LOCK_RUN = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_pulse_i,
  input  logic       lo_pulse_i,
  input  logic [1:0] mode_i,
  output logic       up_o,
  output logic       dn_o,
  output logic       cp_hi_o,
  output logic       amp_en_o,
  output logic       lock_o
);
  ctrl_t      ctrl;
  logic [1:0] rise;
  logic       up_q, dn_q, both;

  pfd_mode_dec u_dec (
    .mode_i (mode_i),
    .ctrl_o (ctrl)
  );

  pfd_edge_det #(.N(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({lo_pulse_i, ref_pulse_i}),
    .rise_o (rise)
  );

  pfd_tristate u_pfd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_rise_i (rise[0]),
    .lo_rise_i  (rise[1]),
    .up_q_o     (up_q),
    .dn_q_o     (dn_q),
    .both_o     (both)
  );

  pfd_lock_det #(.WIN_CYC(WIN_CYC), .LOCK_RUN(LOCK_RUN)) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (ctrl.lock_en),
    .up_q_i   (up_q),
    .dn_q_i   (dn_q),
    .both_i   (both),
    .locked_o (lock_o)
  );

  assign up_o     = up_q & ctrl.pump_en;
  assign dn_o     = dn_q & ctrl.pump_en;
  assign cp_hi_o  = ctrl.cp_hi;
  assign amp_en_o = ctrl.amp_en;
endmodule

// File: rtl/pfd_lock_core_chk.sv
module pfd_lock_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ref_pulse_i,
  input logic       lo_pulse_i,
  input logic [1:0] mode_i,
  input logic       up_o,
  input logic       dn_o,
  input logic       cp_hi_o,
  input logic       amp_en_o,
  input logic       lock_o
);
  logic strap_off;
  assign strap_off = (mode_i == 2'b01) || (mode_i == 2'b10);

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!up_o && !dn_o && !lock_o));

  assert_up_from_ref_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(up_o) && $stable(mode_i)) |-> $past(ref_pulse_i));

  assert_dn_from_lo_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dn_o) && $stable(mode_i)) |-> $past(lo_pulse_i));

  assert_overlap_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o && dn_o) |=> !(up_o && dn_o));

  assert_pump_off_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_off |-> (!up_o && !dn_o));

  assert_amp_open_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10) |-> !amp_en_o);

  assert_lock_after_cmp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(up_o && dn_o));

  assert_lock_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_off |-> !lock_o);

  assert_hi_only_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_hi_o |-> (mode_i == 2'b11));
endmodule

bind pfd_lock_core pfd_lock_core_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ref_pulse_i (ref_pulse_i),
  .lo_pulse_i  (lo_pulse_i),
  .mode_i      (mode_i),
  .up_o        (up_o),
  .dn_o        (dn_o),
  .cp_hi_o     (cp_hi_o),
  .amp_en_o    (amp_en_o),
  .lock_o      (lock_o)
);

// File: tb/pfd_lock_core_tb_top.sv
module pfd_lock_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 25;
  localparam int RUN        = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_p = 1'b0;
  logic       lo_p = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       up, dn, cp_hi, amp_en, lock;

  int n_chk = 0;
  int n_bad = 0;
  int run_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfd_lock_core #(.WIN_CYC(WIN), .LOCK_RUN(RUN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ref_pulse_i(ref_p), .lo_pulse_i(lo_p),
    .mode_i(mode), .up_o(up), .dn_o(dn), .cp_hi_o(cp_hi), .amp_en_o(amp_en),
    .lock_o(lock));

  function automatic bit pump_on_f(logic [1:0] m);
    return (m == 2'b00) || (m == 2'b11);
  endfunction

  function automatic bit amp_f(logic [1:0] m);
    return m != 2'b10;
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_mode(logic [1:0] m);
    @(negedge clk);
    mode = m;
    if (!pump_on_f(m)) run_m = 0;
    #1;
    check("R9 cp_hi", cp_hi, m == 2'b11);
    check("R5 amp_en", amp_en, amp_f(m));
    check("R8 lock gated", lock, pump_on_f(m) && run_m == RUN);
  endtask

  // d > 0: ref leads by d cycles; d < 0: lo leads; d == 0: together
  task automatic compare(int d);
    int  a;
    bit  ref_lead;
    bit  pon;
    a = (d < 0) ? -d : d;
    ref_lead = (d >= 0);
    pon = pump_on_f(mode);
    @(negedge clk);
    if (d == 0) begin
      ref_p = 1'b1; lo_p = 1'b1;
    end else if (ref_lead) ref_p = 1'b1;
    else lo_p = 1'b1;
    for (int i = 1; i <= a; i++) begin
      @(negedge clk);
      if (i == 1) begin
        check("R2 leader set", ref_lead ? up : dn, pon);
        check("R2 lagger idle", ref_lead ? dn : up, 1'b0);
      end
      if (i == 2) begin
        if (ref_lead) ref_p = 1'b0; else lo_p = 1'b0;
      end
    end
    if (d != 0) begin
      if (ref_lead) lo_p = 1'b1; else ref_p = 1'b1;
    end
    @(negedge clk);
    check("R3 overlap up", up, pon);
    check("R3 overlap dn", dn, pon);
    check("R4 pump gate", up && !pon, 1'b0);
    @(negedge clk);
    check("R3 clear", up | dn, 1'b0);
    ref_p = 1'b0; lo_p = 1'b0;
    if (!pump_on_f(mode)) run_m = 0;
    else if (a <= WIN) run_m = (run_m < RUN) ? run_m + 1 : RUN;
    else run_m = 0;
    repeat (3) @(negedge clk);
    check(a > WIN ? "R7 lock after bad" : "R6 lock after good",
          lock, pump_on_f(mode) && run_m == RUN);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check("R1 reset up", up, 1'b0);
    check("R1 reset dn", dn, 1'b0);
    check("R1 reset lock", lock, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", up | dn | lock, 1'b0);

    set_mode(2'b00);
    set_mode(2'b11);
    set_mode(2'b01);
    set_mode(2'b10);
    set_mode(2'b11);

    // R6: six good at window edge, not locked; seventh locks
    for (int k = 0; k < 6; k++) compare((k % 2) ? WIN : -WIN);
    check("R6 six good no lock", lock, 1'b0);
    compare(0);
    check("R6 seventh locks", lock, 1'b1);
    // R7: one past window drops lock
    compare(WIN + 1);
    check("R7 bad drops lock", lock, 1'b0);
    for (int k = 0; k < 7; k++) compare(1);
    check("R7 relock after seven", lock, 1'b1);
    // R8: strap excursion wipes run
    set_mode(2'b01);
    check("R8 mid lock low", lock, 1'b0);
    compare(3);
    set_mode(2'b00);
    for (int k = 0; k < 6; k++) compare(-1);
    check("R8 run restarted", lock, 1'b0);
    compare(2);
    check("R8 relock", lock, 1'b1);

    for (int n = 0; n < 300; n++) begin
      int d;
      if ($urandom_range(0, 19) == 0) set_mode(2'($urandom_range(0, 3)));
      if ($urandom_range(0, 9) == 0) d = WIN + 1 + $urandom_range(0, 8);
      else d = $urandom_range(0, WIN);
      if ($urandom_range(0, 1) == 1) d = -d;
      compare(d);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule